// File: doc/BRIEF.md
# Motor Bridge Fault Supervisor

This block sits between a three-phase gate-drive sequencer and the protection comparators of a bridge driver. Every protection condition reaches it as a digital flag: a bad hall code, two regulator comparator levels (one for the turn-on threshold and one for the drop-out threshold), two die-temperature flags (over-limit and recovered), a desaturation flag and a bootstrap-refresh flag for each phase, and the high-side commands the sequencer is currently issuing. From these flags it produces three signals. `coast` turns off all six gates. `hs_kill` turns off only the high sides. `fault` is the combined fault output. It also produces a turn-on permit for each high side.

Faults are handled differently by type. Hall, regulator and thermal problems are live conditions that coast the motor. Regulator and thermal state each follow a hysteresis band, so that state holds while neither threshold flag is active. A shorted motor lead shows up as desaturation on a high side that is switched on. It is only believed after that high side has been on for a programmable number of clocks. Once believed, it is latched, it removes only the high sides, and the sequencer's commutation strobe clears it. A phase whose bootstrap capacitor is still refreshing loses its high-side permit, but this raises no fault. All outputs are registered and respond one clock after the inputs that cause them.

Top module: `mfs_supervisor`

## Requirements
- R1: While `rst` is 1, on the next clock `coast`=1, `fault`=1, `hs_kill`=0 and `hs_permit`=0. The regulator condition starts in the tripped state, so `coast` stays 1 after reset until `vreg_ok` is seen.
- R2: The regulator condition sets when `vreg_low`=1 (this wins if both flags are 1) and clears when `vreg_ok`=1. With both flags 0 it holds its state. While it is set, `coast` is 1 one clock later.
- R3: The thermal condition sets when `temp_hot`=1 (this wins over `temp_cool`) and clears when `temp_cool`=1. With both flags 0 it holds its state. While it is set, `coast` is 1 one clock later.
- R4: `hall_bad`=1 makes `coast` 1 on the next clock. This condition is not latched: `coast` drops one clock after `hall_bad` returns to 0, provided no other coast cause is present.
- R5: `fault` equals `coast` OR `hs_kill` at every clock.
- R6: Phase i latches a short when `hs_on[i]` and `desat[i]` are both 1 at a clock edge after `hs_on[i]` has already been 1 for QUAL_CYC consecutive edges. `desat[i]` is ignored during those first QUAL_CYC edges. `hs_kill` rises one clock after the latching edge, and the short does not set `coast`.
- R7: A latched short holds `hs_kill` at 1 after `desat` and `hs_on` fall, until an edge where `comm_stb`=1. That edge clears it, and the clear wins over a short detected on the same edge.
- R8: `rst` clears a latched short and restarts the qualification count for every phase.
- R9: `hs_permit[i]` is 1 exactly when `boot_busy[i]`=0, `coast` is 0 and `hs_kill` is 0, all one clock later. `boot_busy` never raises `fault`.
- R10: `desat[i]` has no effect while `hs_on[i]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_bad | input | 1 | Hall decoder reports an illegal code |
| vreg_ok | input | 1 | Regulator is above the turn-on threshold |
| vreg_low | input | 1 | Regulator is below the drop-out threshold |
| temp_hot | input | 1 | Die temperature is above the shutdown limit |
| temp_cool | input | 1 | Die temperature is below the recovery limit |
| hs_on | input | NPH | High-side on command, one bit per phase |
| desat | input | NPH | High-side drain-source drop is too large, one bit per phase |
| boot_busy | input | NPH | Bootstrap refresh current is still high, one bit per phase |
| comm_stb | input | 1 | Start of a commutation step |
| coast | output | 1 | Turn off all gates |
| hs_kill | output | 1 | Turn off all high-side gates |
| fault | output | 1 | Combined fault indication |
| hs_permit | output | NPH | High-side turn-on allowed, one bit per phase |

## Verification
The regulator and thermal flags are pulsed and then released to an idle level. This shows whether the design keeps hysteresis state or just follows the inputs. Pulsing the bad-hall flag alone shows that this condition is live and not latched. Desaturation is held from the very first edge of a high-side command, which places the latching edge exactly and separates it from early transient rejection. The same flag is also raised on a phase whose high side is off. A commutation strobe is placed on the very edge where a short qualifies, to show which of clear and set wins. Bootstrap refresh is raised on one phase only, to show that the permit is per phase and that refresh never reaches `fault`.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  typedef enum logic {HY_CLEAR = 1'b0, HY_TRIP = 1'b1} hy_state_t;

  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/mfs_hyst.sv
module mfs_hyst
  import mfs_pkg::*;
#(
  parameter bit INIT_TRIP = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic trip_nxt,
  output logic trip_q
);
  hy_state_t st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (set_i)      st_n = HY_TRIP;
    else if (clr_i) st_n = HY_CLEAR;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= INIT_TRIP ? HY_TRIP : HY_CLEAR;
    else     st_q <= st_n;
  end

  assign trip_nxt = (st_n == HY_TRIP);
  assign trip_q   = (st_q == HY_TRIP);
endmodule

// File: rtl/mfs_short_phase.sv
module mfs_short_phase
  import mfs_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_on_i,
  input  logic desat_i,
  input  logic clr_i,
  output logic short_nxt,
  output logic short_q
);
  localparam int unsigned CW = cnt_width(QUAL_CYC);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_CYC);

  logic [CW-1:0] cnt_q;
  logic          qual;

  assign qual      = hs_on_i && (cnt_q == CMAX);
  assign short_nxt = clr_i ? 1'b0 : (short_q || (qual && desat_i));

  always_ff @(posedge clk) begin
    if (rst || !hs_on_i) cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) short_q <= 1'b0;
    else     short_q <= short_nxt;
  end
endmodule

// File: rtl/mfs_supervisor.sv
module mfs_supervisor
  import mfs_pkg::*;
#(
  parameter int unsigned NPH      = 3,
  parameter int unsigned QUAL_CYC = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hall_bad,
  input  logic           vreg_ok,
  input  logic           vreg_low,
  input  logic           temp_hot,
  input  logic           temp_cool,
  input  logic [NPH-1:0] hs_on,
  input  logic [NPH-1:0] desat,
  input  logic [NPH-1:0] boot_busy,
  input  logic           comm_stb,
  output logic           coast,
  output logic           hs_kill,
  output logic           fault,
  output logic [NPH-1:0] hs_permit
);
  logic uv_nxt, uv_q, ot_nxt, ot_q;
  logic [NPH-1:0] sh_nxt, sh_q;
  logic coast_n, kill_n;

  mfs_hyst #(.INIT_TRIP(1'b1)) u_uv (
    .clk(clk), .rst(rst), .set_i(vreg_low), .clr_i(vreg_ok),
    .trip_nxt(uv_nxt), .trip_q(uv_q));

  mfs_hyst #(.INIT_TRIP(1'b0)) u_ot (
    .clk(clk), .rst(rst), .set_i(temp_hot), .clr_i(temp_cool),
    .trip_nxt(ot_nxt), .trip_q(ot_q));

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    mfs_short_phase #(.QUAL_CYC(QUAL_CYC)) u_sh (
      .clk(clk), .rst(rst), .hs_on_i(hs_on[p]), .desat_i(desat[p]),
      .clr_i(comm_stb), .short_nxt(sh_nxt[p]), .short_q(sh_q[p]));
  end

  assign coast_n = uv_nxt | ot_nxt | hall_bad;
  assign kill_n  = |sh_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      coast     <= 1'b1;
      hs_kill   <= 1'b0;
      fault     <= 1'b1;
      hs_permit <= '0;
    end else begin
      coast     <= coast_n;
      hs_kill   <= kill_n;
      fault     <= coast_n | kill_n;
      hs_permit <= ~boot_busy & {NPH{~(coast_n | kill_n)}};
    end
  end
endmodule

// File: rtl/mfs_supervisor_chk.sv
module mfs_supervisor_chk #(
  parameter int unsigned NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           hall_bad,
  input logic           vreg_low,
  input logic           temp_hot,
  input logic [NPH-1:0] boot_busy,
  input logic           comm_stb,
  input logic           coast,
  input logic           hs_kill,
  input logic           fault,
  input logic [NPH-1:0] hs_permit
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (coast && fault && !hs_kill && hs_permit == '0)); // R1
  AST_UV_COAST: assert property (@(posedge clk) disable iff (rst)
    vreg_low |=> coast); // R2
  AST_OT_COAST: assert property (@(posedge clk) disable iff (rst)
    temp_hot |=> coast); // R3
  AST_HALL_COAST: assert property (@(posedge clk) disable iff (rst)
    hall_bad |=> coast); // R4
  AST_FAULT_SUM: assert property (@(posedge clk) disable iff (rst)
    fault == (coast || hs_kill)); // R5
  AST_KILL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    comm_stb |=> !hs_kill); // R7
  AST_KILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hs_kill && !comm_stb) |=> hs_kill); // R7
  AST_PERMIT_GATED: assert property (@(posedge clk) disable iff (rst)
    (hs_permit != '0) |-> (!coast && !hs_kill)); // R9
  AST_BOOT_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (boot_busy != '0) |=> ((hs_permit & $past(boot_busy)) == '0)); // R9
endmodule

bind mfs_supervisor mfs_supervisor_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst(rst), .hall_bad(hall_bad), .vreg_low(vreg_low),
  .temp_hot(temp_hot), .boot_busy(boot_busy), .comm_stb(comm_stb),
  .coast(coast), .hs_kill(hs_kill), .fault(fault), .hs_permit(hs_permit));

// File: tb/sim_mfs_supervisor.sv
`timescale 1ns/1ps
module sim_mfs_supervisor;
  localparam int NPH = 3;
  localparam int QC  = 4;

  logic clk = 1'b0;
  logic rst, hall_bad, vreg_ok, vreg_low, temp_hot, temp_cool, comm_stb;
  logic [NPH-1:0] hs_on, desat, boot_busy;
  logic coast, hs_kill, fault;
  logic [NPH-1:0] hs_permit;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mfs_supervisor #(.NPH(NPH), .QUAL_CYC(QC)) u0 (
    .clk(clk), .rst(rst), .hall_bad(hall_bad), .vreg_ok(vreg_ok),
    .vreg_low(vreg_low), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .hs_on(hs_on), .desat(desat), .boot_busy(boot_busy), .comm_stb(comm_stb),
    .coast(coast), .hs_kill(hs_kill), .fault(fault), .hs_permit(hs_permit));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic c, input logic k,
                         input logic [NPH-1:0] p);
    chk(req, "coast", 8'(coast), 8'(c));
    chk(req, "hs_kill", 8'(hs_kill), 8'(k));
    chk(req, "fault", 8'(fault), 8'(c | k));   // R5
    chk(req, "hs_permit", 8'(hs_permit), 8'(p));
  endtask

  task automatic power_up();
    vreg_ok = 1'b1; step(); vreg_ok = 1'b0; step();
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); step();
    chk_out("R1", 1'b1, 1'b0, '0);
    rst = 1'b0; step(); step();
    chk_out("R1", 1'b1, 1'b0, '0);
  endtask

  task automatic t_uv();
    vreg_ok = 1'b1; step(); vreg_ok = 1'b0;
    chk_out("R2", 1'b0, 1'b0, '1);
    step(); chk_out("R2", 1'b0, 1'b0, '1);
    vreg_low = 1'b1; vreg_ok = 1'b1; step(); vreg_ok = 1'b0; vreg_low = 1'b0;
    chk_out("R2", 1'b1, 1'b0, '0);
    step(); step(); chk_out("R2", 1'b1, 1'b0, '0);
    power_up(); chk_out("R2", 1'b0, 1'b0, '1);
  endtask

  task automatic t_ot();
    temp_hot = 1'b1; temp_cool = 1'b1; step(); temp_hot = 1'b0; temp_cool = 1'b0;
    chk_out("R3", 1'b1, 1'b0, '0);
    step(); step(); chk_out("R3", 1'b1, 1'b0, '0);
    temp_cool = 1'b1; step(); temp_cool = 1'b0;
    chk_out("R3", 1'b0, 1'b0, '1);
  endtask

  task automatic t_hall();
    hall_bad = 1'b1; step();
    chk_out("R4", 1'b1, 1'b0, '0);
    hall_bad = 1'b0; step();
    chk_out("R4", 1'b0, 1'b0, '1);
  endtask

  task automatic t_boot();
    boot_busy = 3'b010; step();
    chk_out("R9", 1'b0, 1'b0, 3'b101);
    boot_busy = 3'b000; step();
    chk_out("R9", 1'b0, 1'b0, 3'b111);
  endtask

  task automatic t_off_desat();
    desat = 3'b111;
    for (int i = 0; i < QC + 3; i++) step();
    chk_out("R10", 1'b0, 1'b0, '1);
    desat = '0; step();
  endtask

  task automatic t_short();
    hs_on = 3'b001; desat = 3'b001;
    for (int i = 0; i < QC; i++) begin
      step();
      chk("R6", "hs_kill during qualification", 8'(hs_kill), 8'd0);
    end
    step();
    chk_out("R6", 1'b0, 1'b1, '0);
    hs_on = '0; desat = '0; step(); step();
    chk_out("R7", 1'b0, 1'b1, '0);
    comm_stb = 1'b1; step(); comm_stb = 1'b0;
    chk_out("R7", 1'b0, 1'b0, '1);
  endtask

  task automatic t_clear_wins();
    hs_on = 3'b010; desat = 3'b010;
    for (int i = 0; i < QC; i++) step();
    comm_stb = 1'b1; step(); comm_stb = 1'b0;
    chk("R7", "clear beats same-edge set", 8'(hs_kill), 8'd0);
    step();
    chk("R6", "short latched after strobe", 8'(hs_kill), 8'd1);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R8", "kill cleared by reset", 8'(hs_kill), 8'd0);
    for (int i = 0; i < QC; i++) step();
    chk("R8", "qualification restarted", 8'(hs_kill), 8'd0);
    hs_on = '0; desat = '0;
    power_up();
    chk_out("R8", 1'b0, 1'b0, '1);
  endtask

  initial begin
    rst = 1'b1; hall_bad = 0; vreg_ok = 0; vreg_low = 0; temp_hot = 0;
    temp_cool = 0; comm_stb = 0; hs_on = '0; desat = '0; boot_busy = '0;
    @(negedge clk);
    t_reset();
    t_uv();
    t_ot();
    t_hall();
    t_boot();
    t_off_desat();
    t_short();
    t_clear_wins();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule